// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel word into an asynchronous serial frame on a single output line. A frame is a low start slot, the data bits with the least significant bit first, an optional parity slot and a high stop period. The frame is launched by a rising edge on a level-type send command, so a command left high produces exactly one frame.

The word length (5 to 8 bits), the parity mode (none, even, odd) and the stop length (1, 1.5 or 2 bit periods) are chosen at run time through small select inputs. They are captured together with the word when a frame starts. The bit period is a whole number of clock cycles set by the `CLKS_PER_BIT` parameter; an internal slot counter times every slot. A busy output marks the whole frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high and busy is low; a send command that is already high when reset is released starts no frame.
- R2: A frame starts when the send command is sampled high at a clock edge after being sampled low at the previous edge while the block is idle; in the cycle after that edge the line goes low for exactly `CLKS_PER_BIT` cycles (start slot).
- R3: The data slots follow the start slot, least significant bit first, each lasting `CLKS_PER_BIT` cycles; the count of data bits is 5, 6, 7 or 8 for `len_sel` values 0, 1, 2, 3.
- R4: `par_sel` 1 (even) adds one slot after the data that makes the count of ones in the data plus parity even; `par_sel` 2 (odd) makes it odd; `par_sel` 0 or 3 sends no parity slot.
- R5: The stop period is high and lasts `CLKS_PER_BIT` cycles for `stop_sel` 0 or 3, `CLKS_PER_BIT + CLKS_PER_BIT/2` cycles for `stop_sel` 1, and `2*CLKS_PER_BIT` cycles for `stop_sel` 2.
- R6: Busy is high from the cycle after the starting edge through the last stop cycle, i.e. for exactly the sum of all slot lengths of the frame.
- R7: A command held high does not start a second frame, and rising edges of the command while busy is high are ignored, not remembered.
- R8: The word and the three selects are captured when the frame starts; changing them during the frame does not alter it.
- R9: Between frames the line is high, and a rising command edge seen at the first edge after busy falls starts the next frame at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_cmd | input | 1 | Level send command; its rising edge starts a frame |
| tx_data | input | 8 | Word to send; only the low 5 to 8 bits are used |
| len_sel | input | 2 | Data length: 0=5, 1=6, 2=7, 3=8 bits |
| par_sel | input | 2 | Parity: 0=none, 1=even, 2=odd, 3=none |
| stop_sel | input | 2 | Stop length: 0=1, 1=1.5, 2=2 bit periods, 3=1 |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bench builds the block with `CLKS_PER_BIT` set to 4, so the longest frame is 48 cycles and every one of the 64 combinations of length, parity and stop selects, including the reserved codes, fits in a short run. An even bit period makes the 1.5-period stop an exact 6 cycles, so an off-by-one in the half-period arithmetic shows up as a shifted busy fall. The short frames also leave room for held commands, edges inside a frame, mid-frame input changes and back-to-back starts.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int MAX_BITS = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'b00,
        STOP_ONE_HALF = 2'b01,
        STOP_TWO      = 2'b10,
        STOP_RSVD     = 2'b11
    } stop_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [2:0] last_idx;
        logic       has_par;
        logic       par_bit;
        stop_mode_e stop;
    } frame_cfg_t;

    function automatic logic [MAX_BITS-1:0] mask_word(logic [MAX_BITS-1:0] w, logic [1:0] len);
        logic [MAX_BITS-1:0] m;
        m = {MAX_BITS{1'b1}} >> (2'd3 - len);
        return w & m;
    endfunction

    function automatic frame_cfg_t build_cfg(logic [MAX_BITS-1:0] w, logic [1:0] len,
                                             par_mode_e pm, stop_mode_e sm);
        frame_cfg_t c;
        logic       ones_odd;
        ones_odd   = ^mask_word(w, len);
        c.last_idx = 3'd4 + {1'b0, len};
        c.has_par  = (pm == PAR_EVEN) || (pm == PAR_ODD);
        c.par_bit  = (pm == PAR_ODD) ? ~ones_odd : ones_odd;
        c.stop     = sm;
        return c;
    endfunction

endpackage

// File: rtl/uft_edge_det.sv
module uft_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    // Reset to high so a level already asserted at reset release is not an edge.
    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/uft_slot_timer.sv
module uft_slot_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] slot_len,
    output logic          slot_end
);
    logic [CW-1:0] cnt;

    assign slot_end = run && (cnt == slot_len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || slot_end) cnt <= '0;
        else                         cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/uft_sequencer.sv
module uft_sequencer
    import uft_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int CW           = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [MAX_BITS-1:0] word,
    input  logic [1:0]          len_sel,
    input  logic [1:0]          par_sel,
    input  logic [1:0]          stop_sel,
    input  logic                slot_end,
    output logic [CW-1:0]       slot_len,
    output phase_e              phase,
    output logic                line
);
    localparam int SLOT_ONE      = CLKS_PER_BIT;
    localparam int SLOT_ONE_HALF = CLKS_PER_BIT + CLKS_PER_BIT / 2;
    localparam int SLOT_TWO      = 2 * CLKS_PER_BIT;

    frame_cfg_t          cfg;
    logic [MAX_BITS-1:0] shreg;
    logic [2:0]          bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cfg     <= '0;
            shreg   <= '0;
            bit_idx <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase   <= PH_START;
                        cfg     <= build_cfg(word, len_sel, par_mode_e'(par_sel), stop_mode_e'(stop_sel));
                        shreg   <= word;
                        bit_idx <= '0;
                    end
                end
                PH_START: begin
                    if (slot_end) phase <= PH_DATA;
                end
                PH_DATA: begin
                    if (slot_end) begin
                        shreg <= shreg >> 1;
                        if (bit_idx == cfg.last_idx)
                            phase <= cfg.has_par ? PH_PARITY : PH_STOP;
                        else
                            bit_idx <= bit_idx + 3'd1;
                    end
                end
                PH_PARITY: begin
                    if (slot_end) phase <= PH_STOP;
                end
                PH_STOP: begin
                    if (slot_end) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        slot_len = CW'(SLOT_ONE);
        if (phase == PH_STOP) begin
            unique case (cfg.stop)
                STOP_ONE_HALF: slot_len = CW'(SLOT_ONE_HALF);
                STOP_TWO:      slot_len = CW'(SLOT_TWO);
                default:       slot_len = CW'(SLOT_ONE);
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            PH_START:  line = 1'b0;
            PH_DATA:   line = shreg[0];
            PH_PARITY: line = cfg.par_bit;
            default:   line = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       send_cmd,
    input  logic [7:0] tx_data,
    input  logic [1:0] len_sel,
    input  logic [1:0] par_sel,
    input  logic [1:0] stop_sel,
    output logic       tx_line,
    output logic       busy
);
    localparam int CW = $clog2(2 * CLKS_PER_BIT + 1);

    logic          go;
    logic          slot_end;
    logic [CW-1:0] slot_len;
    phase_e        phase;
    logic          run;

    uft_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (send_cmd),
        .rise  (go)
    );

    assign run = (phase != PH_IDLE);

    uft_slot_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .slot_len (slot_len),
        .slot_end (slot_end)
    );

    uft_sequencer #(.CLKS_PER_BIT(CLKS_PER_BIT), .CW(CW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .word     (tx_data),
        .len_sel  (len_sel),
        .par_sel  (par_sel),
        .stop_sel (stop_sel),
        .slot_end (slot_end),
        .slot_len (slot_len),
        .phase    (phase),
        .line     (tx_line)
    );

    assign busy = run;
endmodule

// File: rtl/uft_tx_checker.sv
module uft_tx_checker #(
    parameter int CPB = 16
) (
    input logic clk,
    input logic rst,
    input logic send_cmd,
    input logic tx_line,
    input logic busy
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R9: idle line stays high
    p_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_line);

    // R2: first busy cycle carries the low start slot
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx_line);

    // R2: a frame only begins after the command was high
    p_start_needs_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(send_cmd));

    // R7: a command held high while idle does not start a frame
    p_no_retrigger_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && send_cmd && $past(send_cmd)) |=> !busy);

    // R5: the frame ends on a high stop level
    p_stop_high_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tx_line));

    // R6: frame length lies between the shortest and longest format
    p_frame_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run >= 7 * CPB) && (busy_run <= 12 * CPB));
endmodule

bind uart_frame_tx uft_tx_checker #(.CPB(CLKS_PER_BIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .send_cmd (send_cmd),
    .tx_line  (tx_line),
    .busy     (busy)
);

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
    localparam int CPB = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       send_cmd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [1:0] len_sel = 2'd0;
    logic [1:0] par_sel = 2'd0;
    logic [1:0] stop_sel = 2'd0;
    logic       tx_line;
    logic       busy;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    uart_frame_tx #(.CLKS_PER_BIT(CPB)) u0 (
        .clk(clk), .rst(rst), .send_cmd(send_cmd), .tx_data(tx_data),
        .len_sel(len_sel), .par_sel(par_sel), .stop_sel(stop_sel),
        .tx_line(tx_line), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit    q_lvl[$];
    string q_tag[$];
    bit    m_prev;

    function automatic int stop_cycles(input logic [1:0] s);
        if (s == 2'd1) return CPB + CPB / 2;
        if (s == 2'd2) return 2 * CPB;
        return CPB;
    endfunction

    function automatic int frame_cycles(input logic [1:0] l, input logic [1:0] p, input logic [1:0] s);
        int hp;
        hp = (p == 2'd1 || p == 2'd2) ? 1 : 0;
        return CPB * (1 + 5 + int'(l) + hp) + stop_cycles(s);
    endfunction

    task automatic push_slot(input bit lvl, input string tag, input int len);
        for (int k = 0; k < len; k++) begin
            q_lvl.push_back(lvl);
            q_tag.push_back(tag);
        end
    endtask

    task automatic build_frame(input logic [7:0] d, input logic [1:0] l,
                               input logic [1:0] p, input logic [1:0] s);
        int nb;
        int ones;
        nb = 5 + int'(l);
        ones = 0;
        push_slot(1'b0, "R2", CPB);
        for (int i = 0; i < nb; i++) begin
            push_slot(d[i], "R3", CPB);
            if (d[i]) ones++;
        end
        if (p == 2'd1) push_slot(bit'(ones % 2), "R4", CPB);
        if (p == 2'd2) push_slot(bit'(1 - ones % 2), "R4", CPB);
        push_slot(1'b1, "R5", stop_cycles(s));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            q_lvl.delete();
            q_tag.delete();
            m_prev = 1'b1;
        end else begin
            if (q_lvl.size() == 0) begin
                if (send_cmd && !m_prev) build_frame(tx_data, len_sel, par_sel, stop_sel);
            end else begin
                void'(q_lvl.pop_front());
                void'(q_tag.pop_front());
            end
            m_prev = send_cmd;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                check(tx_line === 1'b1, "R1 line in reset", int'(tx_line), 1);
                check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
            end else if (q_lvl.size() != 0) begin
                check(tx_line === q_lvl[0], q_tag[0], int'(tx_line), int'(q_lvl[0]));
                check(busy === 1'b1, "R6 busy in frame", int'(busy), 1);
            end else begin
                check(tx_line === 1'b1, "R9 idle line", int'(tx_line), 1);
                check(busy === 1'b0, "R6 busy idle", int'(busy), 0);
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cycles == 150000 && !done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog expired: actual %0d expected %0d", cycles, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_frame(input logic [7:0] d, input logic [1:0] l, input logic [1:0] p,
                            input logic [1:0] s, input bit mid);
        int n;
        int f0;
        @(negedge clk); #1;
        tx_data = d; len_sel = l; par_sel = p; stop_sel = s;
        send_cmd = 1'b1;
        f0 = n_fails;
        n = 0;
        @(negedge clk);
        while (busy && n < 500) begin
            n++;
            if (mid && n == 10) begin
                #1;
                tx_data = ~d; len_sel = ~l; par_sel = p + 2'd1; stop_sel = s + 2'd1;
            end
            @(negedge clk);
        end
        check(n == frame_cycles(l, p, s), "R6 frame length", n, frame_cycles(l, p, s));
        if (mid) check(n_fails == f0, "R8 mid-frame change", n_fails - f0, 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(busy === 1'b0, "R7 held command", int'(busy), 0);
        end
        #1 send_cmd = 1'b0;
    endtask

    initial begin
        // R1: command high through reset release
        send_cmd = 1'b1;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(busy === 1'b0, "R1 held command at reset release", int'(busy), 0);
        end
        #1 send_cmd = 1'b0;

        // R3 R4 R5: all format combinations
        for (int l = 0; l < 4; l++)
            for (int p = 0; p < 4; p++)
                for (int s = 0; s < 4; s++)
                    do_frame(8'(l * 37 + p * 11 + s * 5 + 8'h5A), 2'(l), 2'(p), 2'(s), ((l + p + s) % 3) == 0);

        do_frame(8'h00, 2'd3, 2'd1, 2'd2, 1'b0);
        do_frame(8'hFF, 2'd3, 2'd2, 2'd1, 1'b1);
        do_frame(8'hE0, 2'd0, 2'd2, 2'd0, 1'b0);

        // R7: extra rising edge inside a frame is ignored
        @(negedge clk); #1;
        tx_data = 8'hA5; len_sel = 2'd3; par_sel = 2'd1; stop_sel = 2'd0;
        send_cmd = 1'b1;
        repeat (6) @(negedge clk);
        #1 send_cmd = 1'b0;
        repeat (2) @(negedge clk);
        #1 send_cmd = 1'b1;
        while (busy) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(busy === 1'b0, "R7 edge during frame ignored", int'(busy), 0);
        end

        // R9: back-to-back start right after busy falls
        #1 send_cmd = 1'b0;
        @(negedge clk); #1 send_cmd = 1'b1;
        @(negedge clk);
        while (busy) @(negedge clk);
        check(tx_line === 1'b1, "R9 line high after frame", int'(tx_line), 1);
        #1 send_cmd = 1'b0;
        @(negedge clk); #1 send_cmd = 1'b1;
        @(negedge clk);
        check(busy === 1'b1, "R9 immediate restart", int'(busy), 1);
        check(tx_line === 1'b0, "R2 start slot on restart", int'(tx_line), 0);
        while (busy) @(negedge clk);
        #1 send_cmd = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule